// File: doc/BRIEF.md
# Load/Store Address Watchpoint Comparator

This block watches the data bus of a processor for debug purposes. On every bus cycle flagged by a valid strobe it compares the cycle address against a programmed reference address. Before the comparison it drops the low address bits that the access size makes meaningless: a word access ignores bits 1:0 and a half-word access ignores bit 0. The same bits are dropped from the reference address, so the two operands always line up. A byte access compares every bit.

An unsigned magnitude core produces two raw results, equal and less-than. A programmed compare kind turns them into one event: equal, not equal, greater than or less than. A direction selector limits the event to reads, to writes, to either, or to none. The outcome is registered. The event shows as a single-clock pulse on the clock edge after the edge that sampled the valid cycle.

The magnitude core can be built as one flat comparison or as a tree of slice comparators, chosen by a parameter. Both builds give the same result.

Top module: `lsw_addr_watch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `watch_hit` is 0.
- R2: With compare kind 00 (equal), a valid cycle whose masked address equals the masked reference sets `watch_hit` to 1 on the clock edge after the one that sampled the cycle.
- R3: With compare kind 01 (not equal), the event fires exactly when the masked addresses differ.
- R4: With compare kind 10 (greater than), the event fires when the masked cycle address is unsigned-greater than the masked reference. It does not fire on equality.
- R5: With compare kind 11 (less than), the event fires when the masked cycle address is unsigned-less than the masked reference.
- R6: For a word access (size 10), address bits 1:0 of both the cycle address and the reference are ignored.
- R7: For a half-word access (size 01), only bit 0 of both operands is ignored. Bit 1 still takes part in the comparison.
- R8: For a byte access (size 00), every address bit takes part in the comparison.
- R9: The direction selector gates the event. 00 means never, 01 means reads only (`bus_write`=0), 10 means writes only (`bus_write`=1), and 11 means either. A cycle whose direction is not selected produces no event.
- R10: A clock edge with `bus_valid` low produces `watch_hit`=0 one cycle later. Each valid cycle yields at most a one-clock pulse.
- R11: Size code 11 is treated as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A load/store cycle is present this clock |
| bus_addr | input | AW | Cycle address |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word, 11 word |
| bus_write | input | 1 | 1 for a store, 0 for a load |
| ref_addr | input | AW | Programmed reference address |
| cmp_kind | input | 2 | Event type: 00 equal, 01 not equal, 10 greater, 11 less |
| dir_sel | input | 2 | Direction filter: 00 off, 01 read, 10 write, 11 either |
| watch_hit | output | 1 | Registered one-clock match event |

## Verification
Address masking and direction gating act in the same cycle. Whether a cycle fires depends on both: an address that matches only because of masking must still be blocked by a mismatched direction.

The vector table holds rows where a masked match is paired with an allowed direction and rows where it is paired with a rejected direction, and each row is judged against a single expected pulse.

Two valid cycles back to back also make a new comparison fall in the same cycle as the previous event leaving the register. The bench issues a match followed at once by a miss, and a match followed at once by another match. It then checks that the output drops or holds on exactly the right edge.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      CK_EQ = 2'b00,
      CK_NE = 2'b01,
      CK_GT = 2'b10,
      CK_LT = 2'b11
   } cmp_kind_e;

   typedef enum logic [1:0] {
      DIR_OFF = 2'b00,
      DIR_RD  = 2'b01,
      DIR_WR  = 2'b10,
      DIR_ANY = 2'b11
   } dir_sel_e;

   typedef struct packed {
      logic eq;
      logic lt;
   } cmp_res_t;

endpackage

// File: rtl/lsw_addr_mask.sv
module lsw_addr_mask
   import lsw_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] addr_o
);

   localparam int LOW_W = 2;

   logic [LOW_W-1:0] low_keep;

   always_comb begin
      unique case (acc_size_e'(size_i))
         SZ_BYTE: low_keep = 2'b11;
         SZ_HALF: low_keep = 2'b10;
         default: low_keep = 2'b00;
      endcase
   end

   assign addr_o = {addr_i[AW-1:LOW_W], addr_i[LOW_W-1:0] & low_keep};

endmodule

// File: rtl/lsw_mag_cmp.sv
module lsw_mag_cmp
   import lsw_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SLICE_W = 8,
   parameter bit TREE    = 1'b1
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output cmp_res_t      res_o
);

   localparam int NS = AW / SLICE_W;

   generate
      if (TREE) begin : g_tree
         logic [NS-1:0] s_eq;
         logic [NS-1:0] s_lt;

         for (genvar s = 0; s < NS; s++) begin : g_slice
            logic [SLICE_W-1:0] sa;
            logic [SLICE_W-1:0] sb;
            assign sa      = a_i[s*SLICE_W +: SLICE_W];
            assign sb      = b_i[s*SLICE_W +: SLICE_W];
            assign s_eq[s] = (sa == sb);
            assign s_lt[s] = (sa < sb);
         end

         always_comb begin
            logic eq_acc;
            logic lt_acc;
            eq_acc = 1'b1;
            lt_acc = 1'b0;
            for (int k = NS - 1; k >= 0; k--) begin
               lt_acc = lt_acc | (eq_acc & s_lt[k]);
               eq_acc = eq_acc & s_eq[k];
            end
            res_o.eq = eq_acc;
            res_o.lt = lt_acc;
         end
      end else begin : g_flat
         assign res_o.eq = (a_i == b_i);
         assign res_o.lt = (a_i < b_i);
      end
   endgenerate

endmodule

// File: rtl/lsw_event_sel.sv
module lsw_event_sel
   import lsw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     valid_i,
   input  logic     write_i,
   input  logic [1:0] dir_sel_i,
   input  logic [1:0] kind_i,
   input  cmp_res_t res_i,
   output logic     hit_o
);

   logic dir_ok;
   logic kind_ok;
   logic hit_q;

   always_comb begin
      unique case (dir_sel_e'(dir_sel_i))
         DIR_OFF: dir_ok = 1'b0;
         DIR_RD:  dir_ok = ~write_i;
         DIR_WR:  dir_ok = write_i;
         default: dir_ok = 1'b1;
      endcase
   end

   always_comb begin
      unique case (cmp_kind_e'(kind_i))
         CK_EQ:   kind_ok = res_i.eq;
         CK_NE:   kind_ok = ~res_i.eq;
         CK_GT:   kind_ok = ~res_i.eq & ~res_i.lt;
         default: kind_ok = res_i.lt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= valid_i & dir_ok & kind_ok;
   end

   assign hit_o = hit_q;

   // R10: no valid cycle, no event on the next edge
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !hit_o);

   // R9: a write is never seen by a read-only watch
   assert_dir_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && write_i && dir_sel_i == 2'b01) |=> !hit_o);

   // R4: greater-than never fires on equality
   assert_gt_not_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 2'b10 && res_i.eq) |=> !hit_o);

   // R1: the cycle after reset is released carries no event
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> !hit_o);

endmodule

// File: rtl/lsw_addr_watch.sv
module lsw_addr_watch
   import lsw_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SLICE_W = 8,
   parameter bit TREE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_valid,
   input  logic [AW-1:0] bus_addr,
   input  logic [1:0]    bus_size,
   input  logic          bus_write,
   input  logic [AW-1:0] ref_addr,
   input  logic [1:0]    cmp_kind,
   input  logic [1:0]    dir_sel,
   output logic          watch_hit
);

   generate
      if (AW < 4) begin : g_bad_aw
         $error("lsw_addr_watch: AW must be at least 4");
      end
      if (TREE && (SLICE_W < 1 || (AW % SLICE_W) != 0)) begin : g_bad_slice
         $error("lsw_addr_watch: SLICE_W must divide AW");
      end
   endgenerate

   logic [AW-1:0] cyc_m;
   logic [AW-1:0] ref_m;
   cmp_res_t      raw;

   lsw_addr_mask #(.AW(AW)) u_mask_cyc (
      .addr_i (bus_addr),
      .size_i (bus_size),
      .addr_o (cyc_m)
   );

   lsw_addr_mask #(.AW(AW)) u_mask_ref (
      .addr_i (ref_addr),
      .size_i (bus_size),
      .addr_o (ref_m)
   );

   lsw_mag_cmp #(.AW(AW), .SLICE_W(SLICE_W), .TREE(TREE)) u_cmp (
      .a_i   (cyc_m),
      .b_i   (ref_m),
      .res_o (raw)
   );

   lsw_event_sel u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (bus_valid),
      .write_i   (bus_write),
      .dir_sel_i (dir_sel),
      .kind_i    (cmp_kind),
      .res_i     (raw),
      .hit_o     (watch_hit)
   );

   // R2: the core never reports equal and less-than together
   assert_eq_lt_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(raw.eq && raw.lt));

   // R6: word access matching above bit 1 is an equal event
   assert_word_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_size == 2'b10 && bus_addr[AW-1:2] == ref_addr[AW-1:2]
       && cmp_kind == 2'b00 && dir_sel == 2'b11) |=> watch_hit);

   // R7: half-word access matching above bit 0 is an equal event
   assert_half_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_size == 2'b01 && bus_addr[AW-1:1] == ref_addr[AW-1:1]
       && cmp_kind == 2'b00 && dir_sel == 2'b11) |=> watch_hit);

   // R8: byte access with any differing bit gives no equal event
   assert_byte_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_size == 2'b00 && bus_addr != ref_addr
       && cmp_kind == 2'b00) |=> !watch_hit);

endmodule

// File: tb/tb_lsw_addr_watch.sv
module tb_lsw_addr_watch;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 32;

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  sz;
      logic        wr;
      logic [31:0] rf;
      logic [1:0]  ck;
      logic [1:0]  ds;
      logic        exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 2'b00, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b1, 4'd2},  // R2
      '{32'h0000_1001, 2'b00, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b0, 4'd8},  // R8
      '{32'h0000_1003, 2'b10, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b1, 4'd6},  // R6
      '{32'h0000_1004, 2'b10, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b0, 4'd6},  // R6
      '{32'h0000_1000, 2'b10, 1'b1, 32'h0000_1002, 2'b00, 2'b11, 1'b1, 4'd6},  // R6 ref masked
      '{32'h0000_1001, 2'b01, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b1, 4'd7},  // R7
      '{32'h0000_1002, 2'b01, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b0, 4'd7},  // R7 bit1 kept
      '{32'h0000_1001, 2'b00, 1'b0, 32'h0000_1000, 2'b01, 2'b11, 1'b1, 4'd3},  // R3
      '{32'h0000_1000, 2'b00, 1'b0, 32'h0000_1000, 2'b01, 2'b11, 1'b0, 4'd3},  // R3
      '{32'h0000_2000, 2'b00, 1'b0, 32'h0000_1000, 2'b10, 2'b11, 1'b1, 4'd4},  // R4
      '{32'h0000_1000, 2'b00, 1'b0, 32'h0000_1000, 2'b10, 2'b11, 1'b0, 4'd4},  // R4 equal
      '{32'hF000_0000, 2'b00, 1'b0, 32'h0000_1000, 2'b10, 2'b11, 1'b1, 4'd4},  // R4 unsigned
      '{32'h0000_0FFF, 2'b00, 1'b0, 32'h0000_1000, 2'b11, 2'b11, 1'b1, 4'd5},  // R5
      '{32'hF000_0000, 2'b00, 1'b0, 32'h0000_1000, 2'b11, 2'b11, 1'b0, 4'd5},  // R5 unsigned
      '{32'h0000_1001, 2'b10, 1'b0, 32'h0000_1003, 2'b11, 2'b11, 1'b0, 4'd5},  // R5 masked equal
      '{32'h0000_1003, 2'b10, 1'b0, 32'h0000_1001, 2'b10, 2'b11, 1'b0, 4'd4},  // R4 masked equal
      '{32'h0000_1000, 2'b00, 1'b1, 32'h0000_1000, 2'b00, 2'b01, 1'b0, 4'd9},  // R9 read-only, write
      '{32'h0000_1000, 2'b00, 1'b0, 32'h0000_1000, 2'b00, 2'b01, 1'b1, 4'd9},  // R9 read-only, read
      '{32'h0000_1003, 2'b10, 1'b1, 32'h0000_1000, 2'b00, 2'b10, 1'b1, 4'd9},  // R9 write-only, write
      '{32'h0000_1003, 2'b10, 1'b0, 32'h0000_1000, 2'b00, 2'b10, 1'b0, 4'd9},  // R9 masked match, read
      '{32'h0000_1000, 2'b00, 1'b0, 32'h0000_1000, 2'b00, 2'b00, 1'b0, 4'd9},  // R9 off
      '{32'h0000_1003, 2'b11, 1'b0, 32'h0000_1000, 2'b00, 2'b11, 1'b1, 4'd11}  // R11
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_size = 2'b00;
   logic          bus_write = 1'b0;
   logic [AW-1:0] ref_addr = '0;
   logic [1:0]    cmp_kind = 2'b00;
   logic [1:0]    dir_sel = 2'b11;
   logic          watch_hit;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsw_addr_watch #(.AW(AW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_write (bus_write),
      .ref_addr  (ref_addr),
      .cmp_kind  (cmp_kind),
      .dir_sel   (dir_sel),
      .watch_hit (watch_hit)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: watch_hit actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      bus_addr  = v.addr;
      bus_size  = v.sz;
      bus_write = v.wr;
      ref_addr  = v.rf;
      cmp_kind  = v.ck;
      dir_sel   = v.ds;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10: watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset holds the output low
      repeat (3) @(negedge clk);
      check("R1 in reset", watch_hit, 1'b0);
      apply(VECS[0]);
      bus_valid = 1'b1;
      @(negedge clk);
      check("R1 reset with valid", watch_hit, 1'b0);
      bus_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", watch_hit, 1'b0);

      // table walk: each row is one valid cycle, then a pulse-width check
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         bus_valid = 1'b1;
         @(negedge clk);
         bus_valid = 1'b0;
         check($sformatf("R%0d row %0d", VECS[i].req, i), watch_hit, VECS[i].exp);
         @(negedge clk);
         check($sformatf("R10 pulse end row %0d", i), watch_hit, 1'b0);
      end

      // R10: matching setup but no valid strobe
      apply(VECS[0]);
      bus_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R10 no valid", watch_hit, 1'b0);

      // R2 with R10: match then miss, back to back
      apply(VECS[0]);
      bus_valid = 1'b1;
      @(negedge clk);
      check("R2 first of pair", watch_hit, 1'b1);
      bus_addr = 32'h0000_1004;
      @(negedge clk);
      bus_valid = 1'b0;
      check("R10 miss after match", watch_hit, 1'b0);

      // R2: two matches back to back hold the output for two edges
      @(negedge clk);
      apply(VECS[2]);
      bus_valid = 1'b1;
      @(negedge clk);
      check("R2 back-to-back first", watch_hit, 1'b1);
      bus_addr = 32'h0000_1001;
      @(negedge clk);
      bus_valid = 1'b0;
      check("R6 back-to-back second", watch_hit, 1'b1);
      @(negedge clk);
      check("R10 after pair", watch_hit, 1'b0);

      // R1: reset during a pending event clears it
      apply(VECS[0]);
      bus_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      bus_valid = 1'b0;
      check("R1 reset overrides match", watch_hit, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after second release", watch_hit, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule